// File: doc/BRIEF.md
# Parallel Bus Phase Tracker

This block watches, without driving anything, the control and data lines of an 8-bit parallel SCSI bus. It reports the bus phase in force as both a 4-bit code and a one-hot vector, and gives a one-cycle pulse whenever that phase changes. It checks every transition against the allowed order of phases. A wrong transition sets a sticky violation flag, which stays set until a synchronous clear is applied.

All bus inputs are taken through two-flop synchronisers. A new phase is only accepted once the decoded line state has been steady for a programmable number of clocks, so that skew on the phase lines does not show up as a false phase. While an information transfer phase is active, each rising edge of ACK that arrives while REQ is high latches the data byte. The block then pulses a strobe and reports the byte together with the phase code under which it moved. All bus lines are taken as active-high at this block's pins.

Top module: `bus_phase_tracker`

## Requirements
- R1: `phase_onehot` has exactly one bit set at all times, and that bit is the one at index `phase_code`.
- R2: Phase codes are: 0 free (BSY and SEL both low), 1 selection (SEL high), 2 data out, 3 data in, 4 command, 5 status, 6 message out, 7 message in, and 8 reset (RST high). When BSY is high and SEL is low, {MSG,C/D,I/O} selects the transfer phase: 000 data out, 001 data in, 010 command, 011 status, 110 message out, 111 message in.
- R3: RST high forces code 8 regardless of the current phase. Leaving reset for any phase other than free sets `viol`.
- R4: Moving to free is legal from every phase and never sets `viol`.
- R5: The only other legal moves are free to selection, selection to a transfer phase, and transfer phase to transfer phase in any order. Free to transfer and transfer to selection set `viol`.
- R6: {MSG,C/D,I/O} = 100 or 101 during a transfer phase sets `viol` and leaves `phase_code` unchanged.
- R7: A decoded line state is adopted only after it has been steady for `settle_cnt`+1 clocks. A change shorter than that does not alter `phase_code`.
- R8: `phase_chg` pulses for exactly one clock for each change of `phase_code`.
- R9: `viol` stays set until `clr_viol` is high at a clock edge. If a new violation arrives in the same cycle as the clear, the set wins.
- R10: A rising edge of ACK while REQ is high in a transfer phase gives a one-clock `byte_stb`, with `byte_val` equal to the data lines and `byte_phase` equal to the phase code. An ACK edge without REQ, or outside a transfer phase, gives no strobe.
- R11: After reset, `phase_code` is 0, and `viol` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_viol | input | 1 | Synchronous clear of the violation flag |
| settle_cnt | input | SETTLE_W | Extra steady clocks required before a phase is accepted |
| bus_bsy | input | 1 | BSY line |
| bus_sel | input | 1 | SEL line |
| bus_rst | input | 1 | RST line |
| bus_req | input | 1 | REQ line |
| bus_ack | input | 1 | ACK line |
| bus_msg | input | 1 | MSG line |
| bus_cd | input | 1 | C/D line |
| bus_io | input | 1 | I/O line |
| bus_data | input | DATA_W | Data lines DB0..DB7 |
| phase_code | output | 4 | Current phase code |
| phase_onehot | output | 9 | One-hot phase |
| phase_chg | output | 1 | Phase change pulse |
| viol | output | 1 | Sticky violation flag |
| byte_stb | output | 1 | Byte capture strobe |
| byte_val | output | DATA_W | Captured byte |
| byte_phase | output | 4 | Phase code of captured byte |

## Verification
The hardest state to reach from the ports is leaving reset straight into a transfer phase. This needs RST to fall while BSY and the phase lines are still held, and it must happen after reset had interrupted an active data phase. The bench holds BSY through the fall of RST to force this move. It also pushes one-clock glitches on I/O shorter than the settle window, and walks randomly through the transfer phases with seeded bytes, to check both the filtering and the capture order.

// File: rtl/bpt_pkg.sv
// Package: phase codes and legality rules shared by the tracker modules.
// Assumes codes 2..7 are exactly the information transfer phases.
package bpt_pkg;
    typedef enum logic [3:0] {
        PH_FREE   = 4'd0,
        PH_SELECT = 4'd1,
        PH_DOUT   = 4'd2,
        PH_DIN    = 4'd3,
        PH_CMD    = 4'd4,
        PH_STAT   = 4'd5,
        PH_MOUT   = 4'd6,
        PH_MIN    = 4'd7,
        PH_RESET  = 4'd8,
        PH_RSVD   = 4'd9
    } phase_e;

    localparam int NUM_PHASES = 9;

    // True for the six information transfer phases.
    function automatic logic is_xfer(input logic [3:0] p);
        return (p >= 4'd2) && (p <= 4'd7);
    endfunction

    // True when moving from 'src' to 'dst' respects the bus ordering rules.
    function automatic logic legal_step(input logic [3:0] src, input logic [3:0] dst);
        if (dst == PH_FREE || dst == PH_RESET) return 1'b1;
        if (src == PH_RESET)  return 1'b0;
        if (src == PH_FREE)   return dst == PH_SELECT;
        if (src == PH_SELECT) return is_xfer(dst);
        if (is_xfer(src))     return is_xfer(dst);
        return 1'b0;
    endfunction
endpackage

// File: rtl/bpt_sync.sv
// Two-flop synchroniser for a vector of asynchronous lines.
// Assumes each bit is treated independently; skew between bits is handled
// downstream by the settle filter.
module bpt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;

    // Two stages of capture into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            d_out  <= '0;
        end else begin
            meta_q <= d_in;
            d_out  <= meta_q;
        end
    end
endmodule

// File: rtl/bpt_phase_fsm.sv
// Phase decoder, settle filter and legality checker.
// Assumes synchronised, active-high lines. RST bypasses the settle filter.
module bpt_phase_fsm
    import bpt_pkg::*;
#(
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_viol,
    input  logic [SETTLE_W-1:0] settle_cnt,
    input  logic                s_bsy,
    input  logic                s_sel,
    input  logic                s_rst,
    input  logic                s_msg,
    input  logic                s_cd,
    input  logic                s_io,
    output phase_e              phase,
    output logic                phase_chg,
    output logic                viol
);
    localparam logic [SETTLE_W-1:0] RUN_MAX = {SETTLE_W{1'b1}};

    phase_e              cand, cand_q;
    logic [SETTLE_W-1:0] run;
    logic                settled, adopt, take_rst, viol_set;

    // Decode the line state into a candidate phase.
    always_comb begin
        if (s_rst)       cand = PH_RESET;
        else if (s_sel)  cand = PH_SELECT;
        else if (!s_bsy) cand = PH_FREE;
        else begin
            case ({s_msg, s_cd, s_io})
                3'b000:  cand = PH_DOUT;
                3'b001:  cand = PH_DIN;
                3'b010:  cand = PH_CMD;
                3'b011:  cand = PH_STAT;
                3'b110:  cand = PH_MOUT;
                3'b111:  cand = PH_MIN;
                default: cand = PH_RSVD;
            endcase
        end
    end

    // Decide adoption and violation for this cycle.
    always_comb begin
        settled  = (cand == cand_q) && (run >= settle_cnt);
        take_rst = (cand == PH_RESET) && (phase != PH_RESET);
        adopt    = !take_rst && settled && (cand_q != phase) && (cand_q != PH_RSVD);
        viol_set = (adopt && !legal_step(phase, cand_q)) ||
                   (!take_rst && settled && cand_q == PH_RSVD);
    end

    // Track candidate stability and update phase, pulse and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q    <= PH_FREE;
            run       <= '0;
            phase     <= PH_FREE;
            phase_chg <= 1'b0;
            viol      <= 1'b0;
        end else begin
            cand_q    <= cand;
            run       <= (cand == cand_q) ? ((run == RUN_MAX) ? run : run + 1'b1) : '0;
            phase_chg <= take_rst || adopt;
            if (take_rst)   phase <= PH_RESET;
            else if (adopt) phase <= cand_q;
            if (viol_set)      viol <= 1'b1;
            else if (clr_viol) viol <= 1'b0;
        end
    end

    p_rst_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_RESET && phase != PH_RESET && phase != PH_FREE) |-> viol);
    p_free_no_viol_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) != PH_FREE && phase == PH_FREE && !$past(viol) && !$past(clr_viol)
         && $past(cand_q) != PH_RSVD) |-> !viol);
    p_chg_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_chg |-> (phase != $past(phase)));
    p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(viol) && !$past(clr_viol)) |-> viol);
    p_no_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase != PH_RSVD);
endmodule

// File: rtl/bpt_capture.sv
// Handshake byte capture: latches data on a rising ACK while REQ is high.
// Assumes data lines are synchronised with the same depth as ACK.
module bpt_capture
    import bpt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req,
    input  logic              s_ack,
    input  logic [DATA_W-1:0] s_data,
    input  logic [3:0]        phase,
    output logic              byte_stb,
    output logic [DATA_W-1:0] byte_val,
    output logic [3:0]        byte_phase
);
    logic ack_q;
    logic take;

    // Detect a qualified ACK rising edge.
    always_comb take = s_ack && !ack_q && s_req && is_xfer(phase);

    // Register the edge history and the captured byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q      <= 1'b0;
            byte_stb   <= 1'b0;
            byte_val   <= '0;
            byte_phase <= 4'd0;
        end else begin
            ack_q    <= s_ack;
            byte_stb <= take;
            if (take) begin
                byte_val   <= s_data;
                byte_phase <= phase;
            end
        end
    end

    p_stb_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb);
    p_stb_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> is_xfer(byte_phase));
endmodule

// File: rtl/bus_phase_tracker.sv
// Top: passive parallel bus phase tracker. Synchronises the bus lines,
// tracks the phase with ordering checks, and captures handshake bytes.
// Assumes all bus lines are active-high at these pins; never drives the bus.
module bus_phase_tracker
    import bpt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SETTLE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_viol,
    input  logic [SETTLE_W-1:0]   settle_cnt,
    input  logic                  bus_bsy,
    input  logic                  bus_sel,
    input  logic                  bus_rst,
    input  logic                  bus_req,
    input  logic                  bus_ack,
    input  logic                  bus_msg,
    input  logic                  bus_cd,
    input  logic                  bus_io,
    input  logic [DATA_W-1:0]     bus_data,
    output logic [3:0]            phase_code,
    output logic [NUM_PHASES-1:0] phase_onehot,
    output logic                  phase_chg,
    output logic                  viol,
    output logic                  byte_stb,
    output logic [DATA_W-1:0]     byte_val,
    output logic [3:0]            byte_phase
);
    localparam int CTRL_W = 8;
    localparam int SYNC_W = CTRL_W + DATA_W;

    logic [SYNC_W-1:0] raw, synced;
    phase_e            phase;

    assign raw = {bus_data, bus_bsy, bus_sel, bus_rst, bus_req,
                  bus_ack, bus_msg, bus_cd, bus_io};

    bpt_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw),
        .d_out (synced)
    );

    bpt_phase_fsm #(.SETTLE_W(SETTLE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_viol   (clr_viol),
        .settle_cnt (settle_cnt),
        .s_bsy      (synced[7]),
        .s_sel      (synced[6]),
        .s_rst      (synced[5]),
        .s_msg      (synced[2]),
        .s_cd       (synced[1]),
        .s_io       (synced[0]),
        .phase      (phase),
        .phase_chg  (phase_chg),
        .viol       (viol)
    );

    assign phase_code = phase;

    bpt_capture #(.DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_req      (synced[4]),
        .s_ack      (synced[3]),
        .s_data     (synced[SYNC_W-1:CTRL_W]),
        .phase      (phase_code),
        .byte_stb   (byte_stb),
        .byte_val   (byte_val),
        .byte_phase (byte_phase)
    );

    // One bit per phase code.
    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_onehot
        assign phase_onehot[i] = (phase_code == 4'(i));
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_onehot) == 1);
endmodule

// File: tb/bus_phase_tracker_test.sv
module bus_phase_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_viol = 1'b0;
    logic [3:0] settle_cnt = 4'(SETTLE);
    logic       bsy = 0, sel = 0, brst = 0, req = 0, ack = 0, msg = 0, cd = 0, io = 0;
    logic [7:0] data = 8'h00;
    logic [3:0] phase_code, byte_phase;
    logic [8:0] phase_onehot;
    logic       phase_chg, viol, byte_stb;
    logic [7:0] byte_val;

    int checks = 0, fails = 0;
    int chg_cnt = 0, onehot_bad = 0;
    int exp_n = 0, got_n = 0;
    logic [7:0] exp_b [0:63];
    logic [3:0] exp_p [0:63];
    logic [7:0] got_b [0:63];
    logic [3:0] got_p [0:63];
    logic       rec_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_phase_tracker uut (
        .clk(clk), .rst_n(rst_n), .clr_viol(clr_viol), .settle_cnt(settle_cnt),
        .bus_bsy(bsy), .bus_sel(sel), .bus_rst(brst), .bus_req(req), .bus_ack(ack),
        .bus_msg(msg), .bus_cd(cd), .bus_io(io), .bus_data(data),
        .phase_code(phase_code), .phase_onehot(phase_onehot), .phase_chg(phase_chg),
        .viol(viol), .byte_stb(byte_stb), .byte_val(byte_val), .byte_phase(byte_phase)
    );

    // Expected transfer code from {MSG,C/D,I/O}.
    function automatic logic [3:0] xfer_code(input logic [2:0] l);
        case (l)
            3'b000: return 4'd2;
            3'b001: return 4'd3;
            3'b010: return 4'd4;
            3'b011: return 4'd5;
            3'b110: return 4'd6;
            default: return 4'd7;
        endcase
    endfunction

    // Observe outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (phase_chg) chg_cnt++;
            if (phase_onehot != (9'd1 << phase_code)) onehot_bad++;
            if (byte_stb && got_n < 64) begin
                got_b[got_n] = byte_val;
                got_p[got_n] = byte_phase;
                got_n++;
            end
        end
    end

    task automatic check(input string req_tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req_tag, actual, expected);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle_wait();
        ticks(SETTLE + 8);
    endtask

    task automatic go_xfer(input logic [2:0] l);
        bsy = 1; sel = 0; {msg, cd, io} = l;
        settle_wait();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [3:0] ph);
        data = b; req = 1; ticks(3);
        ack = 1; ticks(4);
        ack = 0; req = 0; ticks(4);
        if (rec_on && exp_n < 64) begin
            exp_b[exp_n] = b; exp_p[exp_n] = ph; exp_n++;
        end
    endtask

    task automatic clear_flag();
        clr_viol = 1; ticks(1); clr_viol = 0; ticks(1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        int c0;
        int nb;
        logic [2:0] l;
        void'($urandom(32'h5EED_0042));
        ticks(3);
        rst_n = 1; ticks(1);
        // R11 reset state
        check("R11 phase", phase_code, 0);
        check("R11 viol", viol, 0);
        check("R11 strobes", {byte_stb, phase_chg}, 0);

        // Typical sequence: free, selection, command, data in, status, message in, free
        rec_on = 1;
        c0 = chg_cnt;
        sel = 1; settle_wait();
        check("R2 selection", phase_code, 1);
        go_xfer(3'b010);
        check("R2 command", phase_code, 4);
        for (int i = 0; i < 6; i++) send_byte(8'($urandom), 4'd4);
        // R7 one-clock glitch on I/O must not move phase
        io = 1; ticks(1); io = 0; settle_wait();
        check("R7 glitch ignored", phase_code, 4);
        go_xfer(3'b001);
        check("R2 data in", phase_code, 3);
        nb = 1 + int'($urandom % 4);
        for (int i = 0; i < nb; i++) send_byte(8'($urandom), 4'd3);
        // R10 ACK without REQ gives no strobe
        data = 8'hEE; ack = 1; ticks(4); ack = 0; ticks(4);
        go_xfer(3'b011);
        check("R2 status", phase_code, 5);
        send_byte(8'($urandom), 4'd5);
        go_xfer(3'b111);
        check("R2 message in", phase_code, 7);
        send_byte(8'($urandom), 4'd7);
        bsy = 0; {msg, cd, io} = 3'b000; settle_wait();
        check("R4 free", phase_code, 0);
        check("R5 legal order no viol", viol, 0);
        check("R8 change count", chg_cnt - c0, 6);

        // R5 random walk through transfer phases, repeats allowed
        sel = 1; settle_wait(); sel = 0;
        for (int k = 0; k < 12; k++) begin
            l = 3'($urandom);
            if (l[2:1] == 2'b10) l = 3'b000;
            go_xfer(l);
            check("R5 walk code", phase_code, xfer_code(l));
            send_byte(8'($urandom), xfer_code(l));
        end
        check("R5 walk no viol", viol, 0);
        // R10 ACK edge outside transfer phase
        bsy = 0; {msg, cd, io} = 3'b000; settle_wait();
        data = 8'h5A; req = 1; ticks(2); ack = 1; ticks(4); ack = 0; req = 0; ticks(4);
        rec_on = 0;
        check("R10 byte count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check("R10 byte value", got_b[i], exp_b[i]);
            check("R10 byte phase", got_p[i], exp_p[i]);
        end

        // R3 reset in the middle of a data phase, released with BSY held
        sel = 1; settle_wait(); go_xfer(3'b000);
        brst = 1; ticks(4);
        check("R3 reset code", phase_code, 8);
        brst = 0; settle_wait();
        check("R3 exit into transfer", phase_code, 2);
        check("R3 viol on bad exit", viol, 1);
        bsy = 0; settle_wait();
        check("R9 sticky", viol, 1);
        clear_flag();
        check("R9 cleared", viol, 0);
        // R3 proper reset exit to free
        brst = 1; ticks(4); brst = 0; settle_wait();
        check("R3 clean exit", phase_code, 0);
        check("R3 clean no viol", viol, 0);

        // R5 free straight to transfer
        go_xfer(3'b011);
        check("R5 free->xfer viol", viol, 1);
        bsy = 0; settle_wait(); clear_flag();
        // R5 transfer back to selection
        sel = 1; settle_wait(); go_xfer(3'b010);
        check("R5 sel->xfer ok", viol, 0);
        sel = 1; settle_wait();
        check("R5 xfer->sel viol", viol, 1);
        sel = 0; bsy = 0; settle_wait(); clear_flag();

        // R6 reserved line code
        sel = 1; settle_wait(); go_xfer(3'b010);
        {msg, cd, io} = 3'b101; settle_wait();
        check("R6 phase held", phase_code, 4);
        check("R6 viol", viol, 1);
        bsy = 0; {msg, cd, io} = 3'b000; settle_wait(); clear_flag();
        check("R4 free after reserved", phase_code, 0);

        check("R1 onehot mismatches", onehot_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule